// File: doc/BRIEF.md
# Prescaled Timer with Match and Capture

This peripheral counts clock cycles on a simple register bus. A free-running divider counter sets the rate: it runs from zero up to a programmable limit and then wraps. On each wrap, the main 32-bit count advances by one. Software can read and rewrite both counters at any time.

Four compare registers watch the main count. Each compare channel has its own three-bit configuration. One bit raises a pending flag, one makes the count restart from zero, and one halts counting by clearing the enable bit. Four capture inputs are synchronized to the clock. A selected edge on an input copies the current count into that channel's capture register and can also raise a flag. All pending flags share one write-one-to-clear register. Their OR drives a single interrupt line.

Register word offsets (byte address, word aligned): flags 0x00, control 0x04, count 0x08, divider limit 0x0C, divider count 0x10, compare configuration 0x14, compare values 0x18 to 0x24, capture configuration 0x28, capture values 0x2C to 0x38. A write needs `bus_sel` and `bus_wr` high with address bits [1:0] zero. Reads are combinational and have no side effects.

Top module: `presc_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: With the divider limit set to D and counting enabled, the divider count steps 0,1,..,D and wraps to 0. On each wrap clock the main count increases by one, so the count advances once every D+1 clocks.
- R3: When control bit 0 (enable) is clear, neither counter changes.
- R4: While control bit 1 (hold) is set, both counters are zero, whatever the state of bit 0.
- R5: The count and the divider count can each be written and read back over the bus.
- R6: When the count steps to compare value i, flags bit i is set if compare configuration bit 3i is set. Without that bit, no flag is set.
- R7: When compare configuration bit 3i+1 is set, the step that would reach compare value i loads 0 instead. With the divider limit at 0, the count then cycles through 0 to value-1.
- R8: When compare configuration bit 3i+2 is set, the step that reaches compare value i loads that value, clears the divider count and clears control bit 0, so both counters stop.
- R9: A bus write that makes the count equal to a compare value does not count as a match.
- R10: Writing 1 to a flags bit clears it. Writing 0 leaves it unchanged.
- R11: Capture input i passes through two synchronizing flops. A rising edge loads capture value i with the count when capture configuration bit 3i is set, and a falling edge does so when bit 3i+1 is set. The new value is readable after the third clock edge following the input change.
- R12: A capture on channel i sets flags bit 4+i only when capture configuration bit 3i+2 is set.
- R13: `irq` is high exactly while any flags bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cap_in | input | 4 | Asynchronous capture inputs |
| irq | output | 1 | Combined pending interrupt |

## Verification
Some rules are checked on every cycle:
- the divider returns to zero after each wrap;
- a wrap advances the count by exactly one unless a restart compare fires;
- hold forces both counters to zero;
- a disabled counter stays still;
- a stop compare clears the enable;
- pending flags stay set unless software writes to the flags register;
- `irq` only rises after a flag-setting event.

Other behaviour can only be shown by the bench's scenarios with known register values:
- the exact compare periods;
- the value and timing of captures;
- edge selection;
- the write-to-count case that must not match;
- the clearing of individual flags.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  parameter int unsigned CNT_W = 32;
  typedef logic [CNT_W-1:0] cnt_t;

  // per-compare configuration, LSB first: irq, restart, halt
  typedef struct packed {
    logic halt_en;
    logic rst_en;
    logic irq_en;
  } mcfg_t;

  // per-capture configuration, LSB first: rising, falling, irq
  typedef struct packed {
    logic irq_en;
    logic fall_en;
    logic rise_en;
  } ccfg_t;

  // word indexes of the fixed registers
  localparam int W_FLAGS  = 0;
  localparam int W_CTRL   = 1;
  localparam int W_COUNT  = 2;
  localparam int W_DIV    = 3;
  localparam int W_DIVCNT = 4;
  localparam int W_MCTL   = 5;
  localparam int W_MVAL0  = 6;

  function automatic cnt_t cnt_inc(input cnt_t v);
    return v + 1'b1;
  endfunction

  function automatic logic div_done(input cnt_t cnt, input cnt_t lim);
    return cnt == lim;
  endfunction

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
  import ptmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  input  cnt_t div_lim,
  input  logic wr_divcnt,
  input  logic wr_count,
  input  cnt_t wdata,
  input  logic restart,
  output logic tick,
  output cnt_t div_cnt,
  output cnt_t count
);

  assign tick = run && div_done(div_cnt, div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (hold) begin
      div_cnt <= '0;
    end else if (wr_divcnt) begin
      div_cnt <= wdata;
    end else if (run) begin
      div_cnt <= tick ? '0 : cnt_inc(div_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (hold) begin
      count <= '0;
    end else if (wr_count) begin
      count <= wdata;
    end else if (tick) begin
      count <= restart ? '0 : cnt_inc(count);
    end
  end

endmodule

// File: rtl/ptmr_match.sv
module ptmr_match
  import ptmr_pkg::*;
#(
  parameter int NMATCH = 4
) (
  input  logic                          tick,
  input  cnt_t                          count,
  input  logic [NMATCH-1:0][CNT_W-1:0]  mval,
  input  mcfg_t [NMATCH-1:0]            mcfg,
  output logic [NMATCH-1:0]             hit,
  output logic [NMATCH-1:0]             flag_set,
  output logic                          any_rst,
  output logic                          any_halt
);

  logic [NMATCH-1:0] rst_req;
  logic [NMATCH-1:0] halt_req;
  cnt_t              next_val;

  assign next_val = cnt_inc(count);

  for (genvar i = 0; i < NMATCH; i++) begin : g_cmp
    assign hit[i]      = tick && (next_val == mval[i]);
    assign flag_set[i] = hit[i] && mcfg[i].irq_en;
    assign rst_req[i]  = hit[i] && mcfg[i].rst_en;
    assign halt_req[i] = hit[i] && mcfg[i].halt_en;
  end

  assign any_rst  = |rst_req;
  assign any_halt = |halt_req;

endmodule

// File: rtl/ptmr_capture.sv
module ptmr_capture
  import ptmr_pkg::*;
#(
  parameter int NCAP = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCAP-1:0]             cap_in,
  input  ccfg_t [NCAP-1:0]            ccfg,
  input  cnt_t                        count,
  output logic [NCAP-1:0]             cap_evt,
  output logic [NCAP-1:0]             flag_set,
  output logic [NCAP-1:0][CNT_W-1:0]  cval
);

  logic [NCAP-1:0] sync_a;
  logic [NCAP-1:0] sync_b;
  logic [NCAP-1:0] prev;
  logic [NCAP-1:0] rise;
  logic [NCAP-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      prev   <= '0;
    end else begin
      sync_a <= cap_in;
      sync_b <= sync_a;
      prev   <= sync_b;
    end
  end

  assign rise = sync_b & ~prev;
  assign fall = ~sync_b & prev;

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    assign cap_evt[i]  = (rise[i] && ccfg[i].rise_en) || (fall[i] && ccfg[i].fall_en);
    assign flag_set[i] = cap_evt[i] && ccfg[i].irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cval[i] <= '0;
      end else if (cap_evt[i]) begin
        cval[i] <= count;
      end
    end
  end

endmodule

// File: rtl/presc_timer.sv
module presc_timer
  import ptmr_pkg::*;
#(
  parameter int NMATCH = 4,
  parameter int NCAP   = 4,
  parameter int AW     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic [NCAP-1:0]  cap_in,
  output logic             irq
);

  localparam int NF      = NMATCH + NCAP;
  localparam int MCTL_W  = 3 * NMATCH;
  localparam int CCTL_W  = 3 * NCAP;
  localparam int W_CCTL  = W_MVAL0 + NMATCH;
  localparam int W_CVAL0 = W_CCTL + 1;

  // bus decode
  logic wr_any;
  int   widx;
  logic wr_flags, wr_ctrl, wr_count, wr_div, wr_divcnt, wr_mctl, wr_cctl;

  assign wr_any    = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
  assign widx      = int'(bus_addr[AW-1:2]);
  assign wr_flags  = wr_any && (widx == W_FLAGS);
  assign wr_ctrl   = wr_any && (widx == W_CTRL);
  assign wr_count  = wr_any && (widx == W_COUNT);
  assign wr_div    = wr_any && (widx == W_DIV);
  assign wr_divcnt = wr_any && (widx == W_DIVCNT);
  assign wr_mctl   = wr_any && (widx == W_MCTL);
  assign wr_cctl   = wr_any && (widx == W_CCTL);

  // configuration state
  logic                          ctrl_en;
  logic                          hold;
  cnt_t                          div_lim;
  logic [MCTL_W-1:0]             mctl_q;
  logic [CCTL_W-1:0]             cctl_q;
  logic [NMATCH-1:0][CNT_W-1:0]  mval;
  logic [NF-1:0]                 flags;

  // internal events
  logic                          run;
  logic                          tick;
  cnt_t                          div_cnt;
  cnt_t                          count;
  logic [NMATCH-1:0]             hit;
  logic [NMATCH-1:0]             m_set;
  logic                          any_rst;
  logic                          any_stop;
  logic [NCAP-1:0]               cap_evt;
  logic [NCAP-1:0]               c_set;
  logic [NCAP-1:0][CNT_W-1:0]    cval;
  logic [NF-1:0]                 flag_set;
  logic [NF-1:0]                 flag_clr;
  mcfg_t [NMATCH-1:0]            mcfg;
  ccfg_t [NCAP-1:0]              ccfg;

  assign run  = ctrl_en && !hold;
  assign mcfg = mctl_q;
  assign ccfg = cctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      hold    <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_en <= bus_wdata[0];
      hold    <= bus_wdata[1];
    end else if (any_stop) begin
      ctrl_en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lim <= '0;
      mctl_q  <= '0;
      cctl_q  <= '0;
    end else begin
      if (wr_div)  div_lim <= bus_wdata;
      if (wr_mctl) mctl_q  <= bus_wdata[MCTL_W-1:0];
      if (wr_cctl) cctl_q  <= bus_wdata[CCTL_W-1:0];
    end
  end

  for (genvar i = 0; i < NMATCH; i++) begin : g_mval
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mval[i] <= '0;
      end else if (wr_any && (widx == W_MVAL0 + i)) begin
        mval[i] <= bus_wdata;
      end
    end
  end

  // pending flags: set wins over clear in the same cycle
  assign flag_set = {c_set, m_set};
  assign flag_clr = wr_flags ? bus_wdata[NF-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags <= (flags & ~flag_clr) | flag_set;
    end
  end

  assign irq = |flags;

  ptmr_prescale u_prescale (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .hold      (hold),
    .div_lim   (div_lim),
    .wr_divcnt (wr_divcnt),
    .wr_count  (wr_count),
    .wdata     (bus_wdata),
    .restart   (any_rst),
    .tick      (tick),
    .div_cnt   (div_cnt),
    .count     (count)
  );

  ptmr_match #(.NMATCH(NMATCH)) u_match (
    .tick     (tick),
    .count    (count),
    .mval     (mval),
    .mcfg     (mcfg),
    .hit      (hit),
    .flag_set (m_set),
    .any_rst  (any_rst),
    .any_halt (any_stop)
  );

  ptmr_capture #(.NCAP(NCAP)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_in   (cap_in),
    .ccfg     (ccfg),
    .count    (count),
    .cap_evt  (cap_evt),
    .flag_set (c_set),
    .cval     (cval)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (widx == W_FLAGS)  bus_rdata[NF-1:0]     = flags;
      if (widx == W_CTRL)   bus_rdata[1:0]        = {hold, ctrl_en};
      if (widx == W_COUNT)  bus_rdata             = count;
      if (widx == W_DIV)    bus_rdata             = div_lim;
      if (widx == W_DIVCNT) bus_rdata             = div_cnt;
      if (widx == W_MCTL)   bus_rdata[MCTL_W-1:0] = mctl_q;
      if (widx == W_CCTL)   bus_rdata[CCTL_W-1:0] = cctl_q;
      for (int i = 0; i < NMATCH; i++) begin
        if (widx == W_MVAL0 + i) bus_rdata = mval[i];
      end
      for (int i = 0; i < NCAP; i++) begin
        if (widx == W_CVAL0 + i) bus_rdata = cval[i];
      end
    end
  end

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
  import ptmr_pkg::*;
#(
  parameter int NF = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          hold,
  input logic          tick,
  input cnt_t          div_cnt,
  input cnt_t          count,
  input logic          wr_divcnt,
  input logic          wr_count,
  input logic          wr_ctrl,
  input logic          wr_flags,
  input logic          ctrl_en,
  input logic          any_rst,
  input logic          any_stop,
  input logic [NF-1:0] flag_set,
  input logic [NF-1:0] flags,
  input logic          irq
);

  // R2
  div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_divcnt) |=> (div_cnt == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_count && !any_rst) |=> (count == cnt_t'($past(count) + 1'b1)));

  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold && !wr_count) |=> $stable(count));

  // R4
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0 && div_cnt == '0));

  // R8
  halt_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stop && !wr_ctrl) |=> !ctrl_en);

  // R10
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flags |=> ((flags & $past(flags)) == $past(flags)));

  // R13
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|flag_set));

endmodule

bind presc_timer ptmr_chk #(.NF(NF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .hold      (hold),
  .tick      (tick),
  .div_cnt   (div_cnt),
  .count     (count),
  .wr_divcnt (wr_divcnt),
  .wr_count  (wr_count),
  .wr_ctrl   (wr_ctrl),
  .wr_flags  (wr_flags),
  .ctrl_en   (ctrl_en),
  .any_rst   (any_rst),
  .any_stop  (any_stop),
  .flag_set  (flag_set),
  .flags     (flags),
  .irq       (irq)
);

// File: tb/test_presc_timer.sv
module test_presc_timer;

  localparam int CLK_P = 10;

  localparam int A_FLAGS  = 8'h00;
  localparam int A_CTRL   = 8'h04;
  localparam int A_COUNT  = 8'h08;
  localparam int A_DIV    = 8'h0C;
  localparam int A_DIVCNT = 8'h10;
  localparam int A_MCTL   = 8'h14;
  localparam int A_MVAL0  = 8'h18;
  localparam int A_CCTL   = 8'h28;
  localparam int A_CVAL0  = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  cap_in = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  presc_timer i_presc_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cap_in    (cap_in),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    bus_addr = 8'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a <= 8'h38; a += 4) begin
      rd_reg(a, v);
      check("R1 register zero after reset", v, 32'h0);
    end
    check("R1 irq low after reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_prescale;
    logic [31:0] v, w;
    wr_reg(A_DIV, 32'd2);
    wr_reg(A_CTRL, 32'h1);
    cycles(9);
    rd_reg(A_COUNT, v);  check("R2 count after 9 clocks, div 3", v, 32'd3);
    rd_reg(A_DIVCNT, v); check("R2 divider wrapped", v, 32'd0);
    cycles(1);
    rd_reg(A_DIVCNT, v); check("R2 divider step", v, 32'd1);
    rd_reg(A_COUNT, v);  check("R2 count between wraps", v, 32'd3);
    wr_reg(A_CTRL, 32'h0);
    rd_reg(A_COUNT, v);
    rd_reg(A_DIVCNT, w);
    cycles(8);
    rd_reg(A_COUNT, bus_wdata);
    check("R3 count frozen when disabled", bus_wdata, v);
    rd_reg(A_DIVCNT, bus_wdata);
    check("R3 divider frozen when disabled", bus_wdata, w);
    wr_reg(A_CTRL, 32'h3);
    cycles(6);
    rd_reg(A_COUNT, v);  check("R4 count zero under hold", v, 32'd0);
    rd_reg(A_DIVCNT, v); check("R4 divider zero under hold", v, 32'd0);
    wr_reg(A_CTRL, 32'h0);
  endtask

  task automatic t_bus_counts;
    logic [31:0] v;
    wr_reg(A_COUNT, 32'hCAFE_0100);
    wr_reg(A_DIVCNT, 32'h0000_0007);
    rd_reg(A_COUNT, v);  check("R5 count write readback", v, 32'hCAFE_0100);
    rd_reg(A_DIVCNT, v); check("R5 divider write readback", v, 32'h0000_0007);
  endtask

  task automatic t_match_restart;
    logic [31:0] v;
    wr_reg(A_CTRL, 32'h2);
    wr_reg(A_DIV, 32'd0);
    wr_reg(A_MVAL0 + 4, 32'd5);
    wr_reg(A_MCTL, 32'h18);          // channel 1: irq + restart
    wr_reg(A_CTRL, 32'h1);
    cycles(4);
    rd_reg(A_COUNT, v); check("R7 count before compare", v, 32'd4);
    rd_reg(A_FLAGS, v); check("R6 no flag before compare", v, 32'h0);
    cycles(1);
    rd_reg(A_FLAGS, v); check("R6 flag bit 1 on compare", v, 32'h2);
    rd_reg(A_COUNT, v); check("R7 restart loads zero", v, 32'd0);
    check("R13 irq with flag pending", {31'h0, irq}, 32'h1);
    cycles(2);
    rd_reg(A_COUNT, v); check("R7 count after restart", v, 32'd2);
    cycles(3);
    rd_reg(A_COUNT, v); check("R7 period of five", v, 32'd0);
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_FLAGS, 32'h1);
    rd_reg(A_FLAGS, v); check("R10 other bit write leaves flag", v, 32'h2);
    wr_reg(A_FLAGS, 32'h0);
    rd_reg(A_FLAGS, v); check("R10 zero write leaves flag", v, 32'h2);
    wr_reg(A_FLAGS, 32'h2);
    rd_reg(A_FLAGS, v); check("R10 one write clears flag", v, 32'h0);
    check("R13 irq low once cleared", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_match_halt;
    logic [31:0] v;
    wr_reg(A_CTRL, 32'h2);
    wr_reg(A_DIV, 32'd1);
    wr_reg(A_MCTL, 32'h100);         // channel 2: halt only
    wr_reg(A_MVAL0 + 8, 32'd3);
    wr_reg(A_CTRL, 32'h1);
    cycles(12);
    rd_reg(A_COUNT, v);  check("R8 count stops at compare value", v, 32'd3);
    rd_reg(A_DIVCNT, v); check("R8 divider stops at zero", v, 32'd0);
    rd_reg(A_CTRL, v);   check("R8 enable cleared", v, 32'h0);
    rd_reg(A_FLAGS, v);  check("R6 no flag without irq bit", v, 32'h0);
    wr_reg(A_MCTL, 32'h40);          // channel 2: irq only
    wr_reg(A_COUNT, 32'd2);
    wr_reg(A_COUNT, 32'd3);
    cycles(2);
    rd_reg(A_FLAGS, v);  check("R9 bus write is not a match", v, 32'h0);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    wr_reg(A_CCTL, 32'h405);         // ch0 rise + irq, ch3 fall only
    wr_reg(A_COUNT, 32'h55);
    cap_in[0] = 1'b1;
    cycles(2);
    rd_reg(A_CVAL0, v); check("R11 capture not yet loaded", v, 32'h0);
    cycles(1);
    rd_reg(A_CVAL0, v); check("R11 rising capture value", v, 32'h55);
    rd_reg(A_FLAGS, v); check("R12 capture flag bit 4", v, 32'h10);
    check("R13 irq from capture", {31'h0, irq}, 32'h1);
    wr_reg(A_COUNT, 32'h77);
    cap_in[0] = 1'b0;
    cycles(4);
    rd_reg(A_CVAL0, v); check("R11 unselected falling edge ignored", v, 32'h55);
    cap_in[3] = 1'b1;
    cycles(4);
    rd_reg(A_CVAL0 + 12, v); check("R11 unselected rising edge ignored", v, 32'h0);
    cap_in[3] = 1'b0;
    cycles(4);
    rd_reg(A_CVAL0 + 12, v); check("R11 falling capture value", v, 32'h77);
    rd_reg(A_FLAGS, v); check("R12 no flag without irq bit", v, 32'h10);
    wr_reg(A_FLAGS, 32'h10);
    rd_reg(A_FLAGS, v); check("R10 capture flag cleared", v, 32'h0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_prescale();
    t_bus_counts();
    t_match_restart();
    t_match_halt();
    t_capture();
    done = 1;
    report();
  end

endmodule